// File: doc/BRIEF.md
# Phantom Register I/O Bridge

This block sits between a processor's memory bus and a simple synchronous I/O bus. Four reserved low memory words act as phantom registers: a read or write aimed at one of them never reaches memory and is turned into a fixed-length I/O cycle to a register of a peripheral. The peripheral is chosen by a 4-bit select code held in a small peripheral-address register, which is itself a memory-mapped word that software loads before touching the phantom words.

The low two bits of the phantom offset form the register code, and the bus direction picks between the peripheral's four writable registers and its four readable ones. The I/O bus has no handshake: the strobe stays high for a parameterised number of clocks and read data is taken on the last of them. Every address other than the phantom words and the peripheral-address word, including the remaining words of the reserved low region, goes to the memory port untouched.

Top module: `phantom_io_bridge`

## Requirements
- R1: After reset the I/O strobe is low, the select register holds 0, and with no bus strobe `cpu_rdy` is low.
- R2: A read or write at addresses 0x0004 to 0x0007 starts an I/O cycle and leaves `mem_rd` and `mem_wr` low throughout.
- R3: During an I/O cycle `io_reg` equals the address minus 4, `io_dir` is 1 for a write and 0 for a read, and `io_sel` equals the select register value at the start of the access.
- R4: `io_strobe` stays high for exactly `IO_CYC` consecutive clocks per access, with `io_sel`, `io_reg`, `io_dir` and `io_wdata` unchanged while it is high.
- R5: For a phantom read, `io_rdata` is captured on the last strobe clock and returned on `cpu_rdata` with `cpu_rdy` high in the clock right after the strobe falls.
- R6: A write at 0x0009 loads bits 3:0 of the data into the select register and ignores bits 15:4; a read at 0x0009 returns the select value in bits 3:0 with bits 15:4 zero; both complete with `cpu_rdy` high in the same clock.
- R7: Any other address (0x0000 to 0x0003, 0x0008, 0x000A upward) drives `mem_addr`, `mem_wdata`, `mem_rd`, `mem_wr` equal to the processor side, returns `mem_rdata` and `mem_rdy`, and never raises `io_strobe`.
- R8: For a phantom write, `io_wdata` carries the processor's write data for the whole strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rd | input | 1 | Read request, held until `cpu_rdy` |
| cpu_wr | input | 1 | Write request, held until `cpu_rdy` |
| cpu_rdata | output | 16 | Read data to processor |
| cpu_rdy | output | 1 | Access complete |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_rdata | input | 16 | Memory read data |
| mem_rdy | input | 1 | Memory access complete |
| io_sel | output | 4 | Peripheral select code |
| io_reg | output | 2 | Register code within the peripheral |
| io_dir | output | 1 | 1 = write to peripheral, 0 = read |
| io_strobe | output | 1 | I/O cycle active |
| io_wdata | output | 16 | Data to peripheral |
| io_rdata | input | 16 | Data from peripheral |

## Verification
The bench builds the bridge with `IO_CYC` = 4 so that the strobe spans several clocks, which exposes an off-by-one in the cycle counter and lets the peripheral model present wrong data on every strobe clock but the last, so data captured early is caught. Select codes 0, 3 and 15 reach both ends of the select range and all four register codes, and an address that aliases a phantom word in its low bits shows that only the full address is decoded. A reset in the middle of a strobe shows the cycle is abandoned and the select register cleared.

// File: rtl/phantom_io_bridge.sv
module phantom_io_bridge #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SW      = 4,
  parameter int IO_CYC  = 3,
  parameter int PA_ADDR = 9,
  parameter int PH_BASE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdy,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic [SW-1:0] io_sel,
  output logic [1:0]    io_reg,
  output logic          io_dir,
  output logic          io_strobe,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata
);

  localparam int CW = (IO_CYC > 1) ? $clog2(IO_CYC) : 1;
  localparam logic [AW-1:0] PH_LO = AW'(PH_BASE);
  localparam logic [AW-1:0] PH_HI = AW'(PH_BASE + 3);
  localparam logic [AW-1:0] PA_AD = AW'(PA_ADDR);
  localparam logic [CW-1:0] LAST  = CW'(IO_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] pa;
  logic [DW-1:0] rbuf;
  logic          req, is_ph, is_pa;

  assign req   = cpu_rd | cpu_wr;
  assign is_ph = (cpu_addr >= PH_LO) && (cpu_addr <= PH_HI);
  assign is_pa = (cpu_addr == PA_AD);

  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign mem_rd    = cpu_rd & ~is_ph & ~is_pa;
  assign mem_wr    = cpu_wr & ~is_ph & ~is_pa;

  assign cpu_rdy   = is_pa ? req : (is_ph ? (st == S_DONE) : mem_rdy);
  assign cpu_rdata = is_pa ? {{(DW-SW){1'b0}}, pa} : (is_ph ? rbuf : mem_rdata);

  assign io_strobe = (st == S_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pa       <= '0;
      rbuf     <= '0;
      io_sel   <= '0;
      io_reg   <= '0;
      io_dir   <= 1'b0;
      io_wdata <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req && is_ph) begin
            st       <= S_BUSY;
            cnt      <= '0;
            io_sel   <= pa;
            io_reg   <= cpu_addr[1:0] - PH_LO[1:0];
            io_dir   <= cpu_wr;
            io_wdata <= cpu_wdata;
          end
          if (cpu_wr && is_pa) pa <= cpu_wdata[SW-1:0];
        end
        S_BUSY: begin
          if (cnt == LAST) begin
            st <= S_DONE;
            if (!io_dir) rbuf <= io_rdata;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module phantom_io_bridge_chk #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SW      = 4,
  parameter int IO_CYC  = 3,
  parameter int PA_ADDR = 9,
  parameter int PH_BASE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_rdy,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [SW-1:0] io_sel,
  input logic [1:0]    io_reg,
  input logic          io_dir,
  input logic          io_strobe,
  input logic [DW-1:0] io_wdata
);

  logic [7:0] run;
  logic       other;

  assign other = (cpu_addr != AW'(PA_ADDR)) &&
                 ((cpu_addr < AW'(PH_BASE)) || (cpu_addr > AW'(PH_BASE + 3)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run <= '0;
    else if (io_strobe) run <= run + 1'b1;
    else                run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !io_strobe); // R1
  AST_STB_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    io_strobe |-> (!mem_rd && !mem_wr)); // R2
  AST_IO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && $past(io_strobe)) |-> ($stable(io_sel) && $stable(io_reg) &&
                                         $stable(io_dir) && $stable(io_wdata))); // R4
  AST_STB_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_strobe) |-> (run == 8'(IO_CYC))); // R4
  AST_RDY_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_strobe) |-> cpu_rdy); // R5
  AST_PA_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == AW'(PA_ADDR)) |-> (cpu_rdata[DW-1:SW] == '0 && cpu_rdy)); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    other |-> (mem_rd == cpu_rd && mem_wr == cpu_wr)); // R7

endmodule

bind phantom_io_bridge phantom_io_bridge_chk #(
  .AW(AW), .DW(DW), .SW(SW), .IO_CYC(IO_CYC), .PA_ADDR(PA_ADDR), .PH_BASE(PH_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_sel(io_sel), .io_reg(io_reg), .io_dir(io_dir), .io_strobe(io_strobe),
  .io_wdata(io_wdata)
);

// File: tb/sim_phantom_io_bridge.sv
`timescale 1ns/1ps
module sim_phantom_io_bridge;
  localparam int CYC = 4;

  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [15:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata, io_wdata, io_rdata;
  logic        cpu_rdy, mem_rd, mem_wr, mem_rdy, io_dir, io_strobe;
  logic [3:0]  io_sel;
  logic [1:0]  io_reg;

  int checks = 0, errors = 0;
  int nstb = 0, nmem = 0, bcnt = 0;
  logic [15:0] mem_dev [32];
  logic [15:0] mem_m [32];
  logic [5:0]  wr_key;
  logic [15:0] wr_dat;
  logic [15:0] pval;

  always #5 clk = ~clk;

  phantom_io_bridge #(.IO_CYC(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .io_sel(io_sel), .io_reg(io_reg),
    .io_dir(io_dir), .io_strobe(io_strobe), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  assign mem_rdy   = mem_rd | mem_wr;
  assign mem_rdata = mem_dev[mem_addr[4:0]];
  assign pval      = {8'hC5, 2'b00, io_sel, io_reg};
  assign io_rdata  = (bcnt == CYC - 1) ? pval : ~pval;

  always @(posedge clk) begin
    if (mem_wr) mem_dev[mem_addr[4:0]] <= mem_wdata;
    if (mem_rd || mem_wr) nmem <= nmem + 1;
    if (io_strobe) begin
      nstb <= nstb + 1;
      bcnt <= bcnt + 1;
      if (io_dir) begin
        wr_key <= {io_sel, io_reg};
        wr_dat <= io_wdata;
      end
    end else bcnt <= 0;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input bit w, input logic [15:0] a, input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    nstb = 0; nmem = 0; wr_key = 'x; wr_dat = 'x;
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = !w;
    #1;
    while (!cpu_rdy) begin
      @(negedge clk);
      #1;
    end
    q = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  localparam logic [32:0] VEC [15] = '{
    {1'b1, 16'h0009, 16'hFFF3},
    {1'b0, 16'h0009, 16'h0000},
    {1'b1, 16'h0005, 16'h1234},
    {1'b0, 16'h0006, 16'h0000},
    {1'b1, 16'h0009, 16'h000F},
    {1'b0, 16'h0007, 16'h0000},
    {1'b1, 16'h0004, 16'hBEEF},
    {1'b1, 16'h0003, 16'h5555},
    {1'b0, 16'h0003, 16'h0000},
    {1'b1, 16'h0008, 16'hAAAA},
    {1'b0, 16'h0008, 16'h0000},
    {1'b1, 16'h0104, 16'h7777},
    {1'b0, 16'h0104, 16'h0000},
    {1'b1, 16'h0009, 16'h0000},
    {1'b0, 16'h0004, 16'h0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [3:0]  pa_m;
    pa_m = 0;
    for (int i = 0; i < 32; i++) begin mem_dev[i] = 0; mem_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!io_strobe && !cpu_rdy && !mem_rd && !mem_wr, "R1 idle outputs",
        {13'b0, io_strobe, cpu_rdy, mem_rd}, 16'h0);
    rst_n = 1;
    bus(0, 16'h0009, 0, q);
    chk(q == 16'h0000, "R1 select after reset", q, 16'h0000);

    for (int i = 0; i < 15; i++) begin
      bit          w;
      logic [15:0] a, d;
      w = VEC[i][32]; a = VEC[i][31:16]; d = VEC[i][15:0];
      bus(w, a, d, q);
      if (a == 16'h0009) begin
        chk(nmem == 0 && nstb == 0, "R6 no memory or io traffic", 16'(nmem + nstb), 16'h0);
        if (w) pa_m = d[3:0];
        else chk(q == {12'b0, pa_m}, "R6 select readback zero-extended", q, {12'b0, pa_m});
      end else if (a >= 16'h0004 && a <= 16'h0007) begin
        chk(nmem == 0, "R2 phantom access kept off memory", 16'(nmem), 16'h0);
        chk(nstb == CYC, "R4 strobe length", 16'(nstb), 16'(CYC));
        if (w) begin
          chk(wr_key == {pa_m, a[1:0]}, "R3 select and register code", {10'b0, wr_key}, {10'b0, pa_m, a[1:0]});
          chk(wr_dat == d, "R8 write data on io bus", wr_dat, d);
        end else begin
          chk(q == {8'hC5, 2'b00, pa_m, a[1:0]}, "R5 read data from last strobe clock", q,
              {8'hC5, 2'b00, pa_m, a[1:0]});
        end
      end else begin
        chk(nstb == 0 && nmem > 0, "R7 pass-through reaches memory only", 16'(nstb), 16'h0);
        if (w) mem_m[a[4:0]] = d;
        else chk(q == mem_m[a[4:0]], "R7 memory read data", q, mem_m[a[4:0]]);
      end
    end

    // R3: direction and select seen while strobe is high, select 10
    bus(1, 16'h0009, 16'h000A, q);
    @(negedge clk);
    cpu_addr = 16'h0006; cpu_rd = 1;
    @(negedge clk);
    chk(io_strobe && !io_dir && io_sel == 4'hA && io_reg == 2'd2, "R3 read cycle fields",
        {9'b0, io_strobe, io_dir, io_sel, 1'b0}, {9'b0, 1'b1, 1'b0, 4'hA, 1'b0});
    // R1: reset during the strobe abandons the cycle and clears select
    rst_n = 0;
    #1;
    chk(!io_strobe && !cpu_rdy, "R1 reset mid-cycle", {14'b0, io_strobe, cpu_rdy}, 16'h0);
    cpu_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    bus(0, 16'h0009, 0, q);
    chk(q == 16'h0000, "R1 select cleared by reset", q, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule